// File: doc/BRIEF.md
# Address-Only Peripheral Select Decoder

This block turns an 8-bit CPU I/O port address into active-low chip selects for up to four peripheral devices. Each device owns a group of four consecutive ports. The two lowest address bits pass straight through so that the device can pick one of its internal registers. The next two bits choose which device is selected.

The decode uses address bits only. No I/O request or write strobe enters the block, so select timing depends only on address timing. Each peripheral qualifies its select with the I/O request strobe on its own pins. Bit 4 of the address acts as a window enable, and an input chooses its polarity. This places the four devices in either the lower or the upper 16 ports of a 32-port window.

The top three address bits are compared with a board base value set on switches. A per-bit compare-enable mask lets any of those bits be ignored. Each ignored bit doubles the number of mirrored copies of the block in the 256-port space. The decoder holds no state, and its outputs follow its inputs directly.

Top module: `pio_addr_decoder`

## Requirements
- R1: `reg_sel` always equals address bits 1:0 (`io_addr[1:0]`), whatever the other inputs are.
- R2: When the window and base checks both pass, exactly `sel_n[k]` is low, where k is the value of `io_addr[3:2]` (0 to 3).
- R3: With `hi_half` = 0, a select can assert only when `io_addr[4]` = 0. With `hi_half` = 1, a select can assert only when `io_addr[4]` = 1. Otherwise all selects are high.
- R4: For each i in 0..2 with `base_cmp[i]` = 1, `io_addr[5+i]` must equal `base_sw[i]`. If any such bit differs, all selects are high.
- R5: An upper address bit whose `base_cmp` bit is 0 has no effect on `sel_n`. Flipping that address bit leaves the selects unchanged, which produces mirrored copies of the block.
- R6: At most one bit of `sel_n` is low at any time.
- R7: All four selects are high whenever the window check (R3) or the base check (R4) fails.
- R8: The block has no clock or strobe input. `sel_n` and `reg_sel` settle to their new values after an address change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_addr | input | 8 | Low byte of the CPU I/O port address |
| base_sw | input | 3 | Switch-set board base, compared with address bits 7:5 |
| base_cmp | input | 3 | Compare enable per base bit; 0 makes that address bit a don't-care |
| hi_half | input | 1 | Window polarity: 0 decodes at address bit 4 low, 1 at bit 4 high |
| sel_n | output | 4 | Active-low peripheral selects, index given by address bits 3:2 |
| reg_sel | output | 2 | Register select for the peripherals, a copy of address bits 1:0 |

## Verification
Every time an input changes, the bound checker confirms these points: the register-select copy matches address bits 1:0, no more than one select is low, a low select always matches address bits 3:2, and every select stays high on a window or base mismatch. It also confirms that a select is asserted whenever both checks pass. The checker cannot show mirroring or the full decode map. The bench covers these by sweeping every address against every base value, mask and polarity, and by flipping each masked address bit to confirm that the selects do not change. A directed step also confirms that the outputs settle between clock edges.

// File: rtl/pio_dec_pkg.sv
// Package: shared defaults and types for the address-only peripheral decoder.
// Assumes address fields are laid out from LSB: register bits, device bits,
// one window bit, then the base-compare bits up to the address MSB.
package pio_dec_pkg;
    localparam int unsigned DEF_ADDR_W = 8;  // I/O address bits decoded
    localparam int unsigned DEF_PORT_W = 2;  // register-select bits per device
    localparam int unsigned DEF_DEV_W  = 2;  // device-index bits

    // Which half of the window the block answers in.
    typedef enum logic {
        WIN_LOW  = 1'b0,
        WIN_HIGH = 1'b1
    } win_pol_e;
endpackage

// File: rtl/pio_base_match.sv
// Module: masked equality compare of upper address bits with a board base.
// Assumes base_cmp bit = 1 means "compare", 0 means "don't care" (mirror).
module pio_base_match #(
    parameter int unsigned BASE_W = 3
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base_sw,
    input  logic [BASE_W-1:0] base_cmp,
    output logic              match
);
    logic [BASE_W-1:0] bit_ok;

    // One matcher per base bit; a masked bit always agrees.
    for (genvar i = 0; i < BASE_W; i++) begin : g_bit
        assign bit_ok[i] = ~base_cmp[i] | ~(addr_hi[i] ^ base_sw[i]);
    end

    // Board matches only when every bit agrees.
    assign match = &bit_ok;
endmodule

// File: rtl/pio_window_gate.sv
// Module: half-window enable from a single address bit with selectable polarity.
// Assumes polarity is static while the CPU runs (set by strap or switch).
module pio_window_gate
    import pio_dec_pkg::*;
(
    input  logic     win_bit,
    input  win_pol_e pol,
    output logic     win_ok
);
    // Window is open when the address bit equals the chosen polarity.
    always_comb begin
        win_ok = (win_bit == logic'(pol));
    end
endmodule

// File: rtl/pio_sel_decode.sv
// Module: binary-to-one-cold decoder for peripheral selects.
// Assumes enable already folds in every board-level qualification.
module pio_sel_decode #(
    parameter int unsigned DEV_W = 2,
    localparam int unsigned NUM_SEL = 1 << DEV_W
) (
    input  logic               enable,
    input  logic [DEV_W-1:0]   idx,
    output logic [NUM_SEL-1:0] sel_n
);
    // One active-low output per device slot.
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        assign sel_n[k] = ~(enable && (idx == DEV_W'(k)));
    end
endmodule

// File: rtl/pio_addr_decoder.sv
// Module: top of the address-only peripheral select decoder.
// Splits the I/O address into register, device, window and base fields and
// produces active-low selects. Purely combinational; no strobe is used, and
// each peripheral qualifies its select with the I/O request itself.
// Assumes ADDR_W > PORT_W + DEV_W + 1 so that at least one base bit exists.
module pio_addr_decoder
    import pio_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PORT_W = DEF_PORT_W,
    parameter int unsigned DEV_W  = DEF_DEV_W,
    localparam int unsigned NUM_SEL  = 1 << DEV_W,
    localparam int unsigned WIN_BIT  = PORT_W + DEV_W,
    localparam int unsigned BASE_LSB = WIN_BIT + 1,
    localparam int unsigned BASE_W   = ADDR_W - BASE_LSB
) (
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [BASE_W-1:0]  base_sw,
    input  logic [BASE_W-1:0]  base_cmp,
    input  logic               hi_half,
    output logic [NUM_SEL-1:0] sel_n,
    output logic [PORT_W-1:0]  reg_sel
);
    logic win_ok;
    logic base_ok;
    logic dec_en;

    // Register-select bits go straight to the peripherals.
    assign reg_sel = io_addr[PORT_W-1:0];

    // Board base compare on the upper address field.
    pio_base_match #(.BASE_W(BASE_W)) u_base (
        .addr_hi  (io_addr[ADDR_W-1:BASE_LSB]),
        .base_sw  (base_sw),
        .base_cmp (base_cmp),
        .match    (base_ok)
    );

    // Half-window enable on the single window bit.
    pio_window_gate u_win (
        .win_bit (io_addr[WIN_BIT]),
        .pol     (win_pol_e'(hi_half)),
        .win_ok  (win_ok)
    );

    // Both board-level checks must pass before any select asserts.
    assign dec_en = win_ok & base_ok;

    // Device index to one-cold selects.
    pio_sel_decode #(.DEV_W(DEV_W)) u_dec (
        .enable (dec_en),
        .idx    (io_addr[WIN_BIT-1:PORT_W]),
        .sel_n  (sel_n)
    );
endmodule

// File: rtl/pio_addr_decoder_chk.sv
// Module: property checker for pio_addr_decoder, attached by bind.
// Assumes purely combinational checks are valid once inputs are not X.
module pio_addr_decoder_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PORT_W = 2,
    parameter int unsigned DEV_W  = 2,
    localparam int unsigned NUM_SEL  = 1 << DEV_W,
    localparam int unsigned WIN_BIT  = PORT_W + DEV_W,
    localparam int unsigned BASE_LSB = WIN_BIT + 1,
    localparam int unsigned BASE_W   = ADDR_W - BASE_LSB
) (
    input logic [ADDR_W-1:0]  io_addr,
    input logic [BASE_W-1:0]  base_sw,
    input logic [BASE_W-1:0]  base_cmp,
    input logic               hi_half,
    input logic [NUM_SEL-1:0] sel_n,
    input logic [PORT_W-1:0]  reg_sel
);
    logic known;
    logic win_miss;
    logic base_miss;

    // Inputs settled to real values; skip checks while anything is X.
    assign known = !$isunknown({io_addr, base_sw, base_cmp, hi_half, sel_n, reg_sel});
    assign win_miss  = (io_addr[WIN_BIT] != hi_half);
    assign base_miss = (((io_addr[ADDR_W-1:BASE_LSB] ^ base_sw) & base_cmp) != '0);

    // Port-level properties, re-evaluated on every input change.
    always_comb begin
        if (known) begin
            a_r1_reg_pass: assert (reg_sel == io_addr[PORT_W-1:0])
                else $error("R1 reg_sel does not follow address");
            a_r6_one_select: assert ($countones(~sel_n) <= 1)
                else $error("R6 more than one select low");
            a_r3_window_off: assert (!win_miss || (&sel_n))
                else $error("R3 select asserted outside window");
            a_r4_base_off: assert (!base_miss || (&sel_n))
                else $error("R4 select asserted on base mismatch");
            a_r2_hit_asserts: assert (win_miss || base_miss
                                      || !sel_n[io_addr[WIN_BIT-1:PORT_W]])
                else $error("R2 expected select not asserted");
            for (int k = 0; k < NUM_SEL; k++) begin
                a_r2_index_match: assert (sel_n[k]
                                          || (io_addr[WIN_BIT-1:PORT_W] == DEV_W'(k)))
                    else $error("R2 select %0d low for wrong index", k);
            end
        end
    end
endmodule

bind pio_addr_decoder pio_addr_decoder_chk #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W),
    .DEV_W  (DEV_W)
) u_chk (
    .io_addr  (io_addr),
    .base_sw  (base_sw),
    .base_cmp (base_cmp),
    .hi_half  (hi_half),
    .sel_n    (sel_n),
    .reg_sel  (reg_sel)
);

// File: tb/test_pio_addr_decoder.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of address, base, mask and polarity with an
// arithmetic reference; mirror-bit flips; directed between-edge settle test.
module test_pio_addr_decoder;
    logic       clk = 1'b0;
    logic [7:0] io_addr = '0;
    logic [2:0] base_sw = '0;
    logic [2:0] base_cmp = '0;
    logic       hi_half = 1'b0;
    logic [3:0] sel_n;
    logic [1:0] reg_sel;
    int         n_vec = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    pio_addr_decoder i_pio_addr_decoder (
        .io_addr  (io_addr),
        .base_sw  (base_sw),
        .base_cmp (base_cmp),
        .hi_half  (hi_half),
        .sel_n    (sel_n),
        .reg_sel  (reg_sel)
    );

    // Reference: selects computed from the requirements.
    function automatic logic [3:0] ref_sel(input logic [7:0] a, input logic [2:0] b,
                                           input logic [2:0] m, input logic h);
        if (a[4] != h) return 4'hF;
        if (((a[7:5] ^ b) & m) != 3'b000) return 4'hF;
        return ~(4'b0001 << a[3:2]);
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h base=%b cmp=%b hi=%b: got %b expected %b",
                     req, io_addr, base_sw, base_cmp, hi_half, got, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] base_res;
        string      tag;
        @(negedge clk);
        // Power-up state, R7: window closed, so all selects high.
        io_addr = 8'h00; hi_half = 1'b1; base_sw = 3'b000; base_cmp = 3'b111;
        #2 check("R7", sel_n, 4'hF);

        // Full sweep: every polarity, mask, base and address.
        for (int h = 0; h < 2; h++) begin
            for (int m = 0; m < 8; m++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int a = 0; a < 256; a++) begin
                        @(negedge clk);
                        io_addr = 8'(a); base_sw = 3'(b); base_cmp = 3'(m); hi_half = h[0];
                        #2;  // no clock edge in between: R8
                        base_res = ref_sel(io_addr, base_sw, base_cmp, hi_half);
                        if (io_addr[4] != hi_half) tag = "R3";
                        else if (((io_addr[7:5] ^ base_sw) & base_cmp) != 3'b000) tag = "R4/R7";
                        else tag = "R2";
                        check(tag, sel_n, base_res);
                        check("R1", {2'b00, reg_sel}, {2'b00, io_addr[1:0]});
                        check("R6", ($countones(~sel_n) <= 1) ? 4'h1 : 4'h0, 4'h1);
                        // R5: flipping a masked upper bit leaves the selects unchanged.
                        for (int i = 0; i < 3; i++) begin
                            if (!base_cmp[i]) begin
                                io_addr[5+i] = ~io_addr[5+i];
                                #1 check("R5", sel_n, base_res);
                                io_addr[5+i] = ~io_addr[5+i];
                                #1;
                            end
                        end
                    end
                end
            end
        end

        // R8 directed: step the address just after a rising edge, sample before the next.
        base_sw = 3'b101; base_cmp = 3'b111; hi_half = 1'b0;
        @(posedge clk);
        #1 io_addr = {3'b101, 1'b0, 2'd3, 2'd2};
        #2 check("R8", sel_n, 4'b0111);
        check("R8", {2'b00, reg_sel}, 4'b0010);
        #1 io_addr = {3'b101, 1'b0, 2'd0, 2'd1};
        #2 check("R8", sel_n, 4'b1110);

        summary();
        $finish;
    end
endmodule